// File: doc/BRIEF.md
# SMBus Host Notify Receiver

This block listens on a two-wire SMBus segment as a target and accepts one message type: the Host Notify frame. Another device on the bus sends that frame to tell the host that something needs attention. Both bus lines are sampled by the system clock. Each line passes through a synchronizer and a glitch filter before Start, Stop and clock edges are decoded from it. When the first byte carries the fixed host address, the block acknowledges. It then clocks in the notifier's 7-bit address and a 16-bit data word, and acknowledges each of those bytes as well.

The captured values move into the readable registers only when the whole frame has arrived and a Stop closes it. At that point a sticky status flag sets. The interrupt output stays high while both that flag and an enable bit are set. Software reads the captured values and then clears the flag by writing a one to it.

While the flag is still set, the block refuses any new notify by leaving the acknowledge slot after the address byte high. It then ignores the bus until the next Start, so the values already held are not overwritten.

Top module: `notify_rx`

## Requirements
- R1: After reset, all four registers read zero, `irq` is 0 and `sda_drive_low` is 0.
- R2: A first byte whose upper seven bits are 0001000 (MSB first) is acknowledged in the ninth clock slot when the status flag is 0. Acknowledge means `sda_drive_low` is 1, so the bus SDA is low while SCL is high.
- R3: The lowest bit of the first byte (the read/write bit) is ignored. An address byte of 0x11 is acknowledged and completes a notify exactly as 0x10 does.
- R4: A first byte with any other 7-bit address gets no acknowledge in any slot, and no register changes.
- R5: A completed frame loads the registers. The upper seven bits of the second byte go into offset 1 (bits 6:0, and the filler bit is dropped). The third byte goes into offset 2 (low data) and the fourth byte into offset 3 (high data). The block acknowledges the second, third and fourth bytes.
- R6: When a frame completes, status bit 0 at offset 0 becomes 1. The frame is complete when four acknowledged bytes are followed by a Stop.
- R7: While status is 1, the slot after the address byte is left high (NACK). No later slot of that frame is acknowledged, and the stored values do not change.
- R8: A frame cut short by a Stop or a repeated Start before it completes leaves status and all stored values unchanged.
- R9: Writing offset 0 with bit 0 set clears status. Writing it with bit 0 clear leaves status as it was.
- R10: Bit 1 at offset 0 is an interrupt enable that reads back as written. `irq` equals status AND enable.
- R11: An SDA pulse lasting two system clocks or less while SCL is high is treated as neither Start nor Stop, and it does not change the sampled bit.
- R12: The acknowledge drive begins while SCL is low, before the acknowledge clock rises. It ends after that clock falls, before the following data bit is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL bus level |
| sda_i | input | 1 | Sampled SDA bus level |
| sda_drive_low | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_addr | input | 2 | Register offset: 0 status/enable, 1 device address, 2 data low, 3 data high |
| reg_wr | input | 1 | Write strobe for offset 0 |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| irq | output | 1 | Interrupt, high while status and enable are both 1 |

## Verification
The bench sends every one of the 128 possible 7-bit addresses. Only 0001000 may be acknowledged, so a wrong address compare would acknowledge a foreign address or miss the real one. It sends a notify while status is still set. A design that ignored the pending flag would acknowledge that frame and overwrite the held values. It also cuts frames short with an early Stop and with a repeated Start just before the Stop, to catch a design that commits on the last acknowledge instead of on the Stop. Other frames carry a two-cycle SDA glitch, or set the read/write bit. The bench probes the drive just before the acknowledge clock rises and just after it falls, which exposes an acknowledge that starts or ends one SCL edge off.

// File: rtl/notify_rx_pkg.sv
package notify_rx_pkg;

    localparam int BYTE_W      = 8;
    localparam int ADDR_W      = 7;
    localparam int FRAME_BYTES = 4;
    localparam int BIT_CNT_W   = $clog2(BYTE_W + 1);
    localparam int BYTE_IDX_W  = $clog2(FRAME_BYTES);
    localparam int REG_OFS_W   = 2;

    localparam logic [ADDR_W-1:0] HOST_ADDR = 7'b0001000;

    localparam logic [REG_OFS_W-1:0] OFS_CTRL = 2'd0;
    localparam logic [REG_OFS_W-1:0] OFS_DEV  = 2'd1;
    localparam logic [REG_OFS_W-1:0] OFS_LO   = 2'd2;
    localparam logic [REG_OFS_W-1:0] OFS_HI   = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_ACK,
        ST_HOLD,
        ST_IGNORE
    } rx_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] dev;
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
    } notify_rec_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    function automatic logic host_addr_hit(input logic [BYTE_W-1:0] b);
        return b[BYTE_W-1:1] == HOST_ADDR;
    endfunction

endpackage

// File: rtl/nrx_line_filter.sv
module nrx_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic clean
);
    localparam int CNT_W = $clog2(FILT_CYC + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       cnt_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            cnt_q  <= '0;
            clean  <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
            if (synced != clean) begin
                if (cnt_q == CNT_W'(FILT_CYC - 1)) begin
                    clean <= synced;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end
endmodule

// File: rtl/nrx_bus_events.sv
module nrx_bus_events
    import notify_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl,
    input  logic     sda,
    output bus_evt_t evt
);
    logic scl_prev_q;
    logic sda_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl;
            sda_prev_q <= sda;
        end
    end

    always_comb begin
        evt.start    = scl_prev_q & scl & sda_prev_q & ~sda;
        evt.stop     = scl_prev_q & scl & ~sda_prev_q & sda;
        evt.scl_rise = ~scl_prev_q & scl;
        evt.scl_fall = scl_prev_q & ~scl;
        evt.sda      = sda;
    end
endmodule

// File: rtl/nrx_frame_fsm.sv
module nrx_frame_fsm
    import notify_rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  bus_evt_t    evt,
    input  logic        busy,
    output logic        drive_low,
    output logic        commit,
    output notify_rec_t work
);
    localparam logic [BYTE_IDX_W-1:0] LAST_IDX = BYTE_IDX_W'(FRAME_BYTES - 1);

    rx_state_e             state_q;
    logic [BIT_CNT_W-1:0]  bit_cnt_q;
    logic [BYTE_IDX_W-1:0] byte_idx_q;
    logic [BYTE_W-1:0]     shift_q;
    logic                  byte_full;

    assign byte_full = (bit_cnt_q == BIT_CNT_W'(BYTE_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            bit_cnt_q  <= '0;
            byte_idx_q <= '0;
            shift_q    <= '0;
            work       <= '0;
            drive_low  <= 1'b0;
            commit     <= 1'b0;
        end else begin
            commit <= 1'b0;
            if (evt.start) begin
                state_q    <= ST_SHIFT;
                bit_cnt_q  <= '0;
                byte_idx_q <= '0;
                drive_low  <= 1'b0;
            end else if (evt.stop) begin
                commit    <= (state_q == ST_HOLD);
                state_q   <= ST_IDLE;
                drive_low <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_SHIFT: begin
                        if (evt.scl_rise && !byte_full) begin
                            shift_q   <= {shift_q[BYTE_W-2:0], evt.sda};
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                        if (evt.scl_fall && byte_full) begin
                            if (byte_idx_q == '0) begin
                                if (host_addr_hit(shift_q) && !busy) begin
                                    state_q   <= ST_ACK;
                                    drive_low <= 1'b1;
                                end else begin
                                    state_q <= ST_IGNORE;
                                end
                            end else begin
                                state_q   <= ST_ACK;
                                drive_low <= 1'b1;
                                if (byte_idx_q == BYTE_IDX_W'(1))
                                    work.dev <= shift_q[BYTE_W-1:1];
                                else if (byte_idx_q == BYTE_IDX_W'(2))
                                    work.lo <= shift_q;
                                else
                                    work.hi <= shift_q;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (evt.scl_fall) begin
                            drive_low <= 1'b0;
                            bit_cnt_q <= '0;
                            if (byte_idx_q == LAST_IDX) begin
                                state_q <= ST_HOLD;
                            end else begin
                                byte_idx_q <= byte_idx_q + 1'b1;
                                state_q    <= ST_SHIFT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/nrx_regs.sv
module nrx_regs
    import notify_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 commit,
    input  notify_rec_t          work,
    input  logic [REG_OFS_W-1:0] reg_addr,
    input  logic                 reg_wr,
    input  logic [BYTE_W-1:0]    reg_wdata,
    output logic [BYTE_W-1:0]    reg_rdata,
    output logic                 status,
    output logic                 irq_en,
    output notify_rec_t          stored
);
    logic ctrl_wr;

    assign ctrl_wr = reg_wr && (reg_addr == OFS_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= 1'b0;
            irq_en <= 1'b0;
            stored <= '0;
        end else begin
            if (commit) begin
                stored <= work;
                status <= 1'b1;
            end else if (ctrl_wr && reg_wdata[0]) begin
                status <= 1'b0;
            end
            if (ctrl_wr)
                irq_en <= reg_wdata[1];
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_CTRL: reg_rdata = {{(BYTE_W-2){1'b0}}, irq_en, status};
            OFS_DEV:  reg_rdata = {1'b0, stored.dev};
            OFS_LO:   reg_rdata = stored.lo;
            default:  reg_rdata = stored.hi;
        endcase
    end
endmodule

// File: rtl/notify_rx.sv
module notify_rx
    import notify_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_drive_low,
    input  logic [REG_OFS_W-1:0] reg_addr,
    input  logic                 reg_wr,
    input  logic [BYTE_W-1:0]    reg_wdata,
    output logic [BYTE_W-1:0]    reg_rdata,
    output logic                 irq
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] clean_lines;
    logic             scl_clean;
    logic             sda_clean;
    bus_evt_t         evt;
    logic             commit;
    notify_rec_t      frame_rec;
    notify_rec_t      stored_rec;
    logic             status_q;
    logic             irq_en_q;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : gen_line
        nrx_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_CYC   (FILT_CYC)
        ) u_filt (
            .clk  (clk),
            .rst  (rst),
            .raw  (raw_lines[g]),
            .clean(clean_lines[g])
        );
    end

    assign scl_clean = clean_lines[1];
    assign sda_clean = clean_lines[0];

    nrx_bus_events u_evt (
        .clk(clk),
        .rst(rst),
        .scl(scl_clean),
        .sda(sda_clean),
        .evt(evt)
    );

    nrx_frame_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .busy     (status_q),
        .drive_low(sda_drive_low),
        .commit   (commit),
        .work     (frame_rec)
    );

    nrx_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .work     (frame_rec),
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .status   (status_q),
        .irq_en   (irq_en_q),
        .stored   (stored_rec)
    );

    assign irq = status_q & irq_en_q;
endmodule

// File: rtl/notify_rx_chk.sv
module notify_rx_chk
    import notify_rx_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 scl_clean,
    input logic                 sda_drive_low,
    input logic                 commit,
    input logic                 status_q,
    input notify_rec_t          stored_rec,
    input logic                 reg_wr,
    input logic [REG_OFS_W-1:0] reg_addr,
    input logic [BYTE_W-1:0]    reg_wdata,
    input logic                 irq
);
    // R12
    ack_starts_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_drive_low) |-> !scl_clean);

    // R7
    no_commit_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        commit |-> !status_q);

    // R8
    stored_only_on_commit_chk: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(stored_rec));

    // R6
    status_set_by_commit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status_q) |-> $past(commit));

    // R9
    status_w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_CTRL && reg_wdata[0] && !commit) |=> !status_q);

    // R10
    irq_off_when_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_CTRL && !reg_wdata[1]) |=> !irq);
endmodule

bind notify_rx notify_rx_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .scl_clean    (scl_clean),
    .sda_drive_low(sda_drive_low),
    .commit       (commit),
    .status_q     (status_q),
    .stored_rec   (stored_rec),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .irq          (irq)
);

// File: tb/notify_rx_bench.sv
module notify_rx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 16;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_bus;
    logic       sda_drive_low;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    assign sda_bus = sda_m & ~sda_drive_low;

    always #(CLK_PERIOD/2) clk = ~clk;

    notify_rx u_notify_rx (
        .clk          (clk),
        .rst          (rst),
        .scl_i        (scl_m),
        .sda_i        (sda_bus),
        .sda_drive_low(sda_drive_low),
        .reg_addr     (reg_addr),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .irq          (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk);
        reg_addr  = 2'd0;
        reg_wdata = v;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic bus_start;
        wait_cyc(HALF/2);
        sda_m = 1'b1;
        wait_cyc(HALF/2);
        scl_m = 1'b1;
        wait_cyc(HALF);
        sda_m = 1'b0;
        wait_cyc(HALF);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop;
        wait_cyc(HALF/2);
        sda_m = 1'b0;
        wait_cyc(HALF/2);
        scl_m = 1'b1;
        wait_cyc(HALF);
        sda_m = 1'b1;
        wait_cyc(HALF);
    endtask

    task automatic send_bit(input logic v, input bit glitch);
        wait_cyc(HALF/2);
        sda_m = v;
        wait_cyc(HALF/2);
        scl_m = 1'b1;
        if (glitch) begin
            wait_cyc(4);
            sda_m = 1'b0;
            wait_cyc(2);
            sda_m = v;
            wait_cyc(HALF - 6);
        end else begin
            wait_cyc(HALF);
        end
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch,
                             output logic ack, output logic timing_ok);
        logic early;
        logic late;
        for (int i = 7; i >= 0; i--)
            send_bit(b[i], glitch && (i == 7));
        wait_cyc(HALF/2);
        sda_m = 1'b1;
        wait_cyc(HALF/2 - 2);
        early = sda_drive_low;
        wait_cyc(2);
        scl_m = 1'b1;
        wait_cyc(HALF/2);
        ack = ~sda_bus;
        wait_cyc(HALF/2);
        scl_m = 1'b0;
        wait_cyc(HALF/2 + 4);
        late = sda_drive_low;
        timing_ok = early & ~late;
    endtask

    task automatic run_frame(input logic [31:0] bytes, input int nbytes, input bit restart_end,
                             input int glitch_byte, output logic [3:0] acks, output logic tim_ok);
        logic a;
        logic t;
        acks   = 4'b0;
        tim_ok = 1'b1;
        bus_start();
        for (int i = 0; i < nbytes; i++) begin
            send_byte(bytes[31 - 8*i -: 8], glitch_byte == i, a, t);
            acks[i] = a;
            if (a) tim_ok = tim_ok & t;
        end
        if (restart_end) bus_start();
        bus_stop();
    endtask

    task automatic check_regs(input string tag, input logic [6:0] dev,
                              input logic [7:0] lo, input logic [7:0] hi);
        logic [7:0] v;
        rd(2'd1, v); check({tag, " device address"}, {24'd0, v}, {25'd0, dev});
        rd(2'd2, v); check({tag, " data low"}, {24'd0, v}, {24'd0, lo});
        rd(2'd3, v); check({tag, " data high"}, {24'd0, v}, {24'd0, hi});
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [3:0] acks;
        logic       tok;
        logic [6:0] e_dev;
        logic [7:0] e_lo;
        logic [7:0] e_hi;
        int         sweep_bad;

        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(2);

        // R1: reset state
        rd(2'd0, v); check("R1 ctrl", {24'd0, v}, 32'd0);
        check_regs("R1", 7'd0, 8'd0, 8'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 drive", {31'd0, sda_drive_low}, 32'd0);

        // R2 / R4: address sweep, address byte then Stop
        sweep_bad = 0;
        for (int a = 0; a < 128; a++) begin
            run_frame({a[6:0], 1'b0, 24'd0}, 1, 1'b0, -1, acks, tok);
            if (acks[0] !== (a == 8)) begin
                sweep_bad++;
                $display("FAIL %s addr=0x%0h actual=%0b expected=%0b",
                         (a == 8) ? "R2" : "R4", a, acks[0], (a == 8));
            end
        end
        n_tests++;
        if (sweep_bad != 0) n_fail++;
        // R8: truncated frames left nothing behind
        rd(2'd0, v); check("R8 status after short frames", {24'd0, v}, 32'd0);
        check_regs("R8 short", 7'd0, 8'd0, 8'd0);

        // R5 / R6 / R12: full notify
        e_dev = 7'h35; e_lo = 8'hA7; e_hi = 8'h5C;
        run_frame({8'h10, e_dev, 1'b0, e_lo, e_hi}, 4, 1'b0, -1, acks, tok);
        check("R5 acks", {28'd0, acks}, 32'hF);
        check("R12 ack drive timing", {31'd0, tok}, 32'd1);
        check_regs("R5", e_dev, e_lo, e_hi);
        rd(2'd0, v); check("R6 status set", {24'd0, v}, 32'h1);
        check("R10 irq disabled", {31'd0, irq}, 32'd0);

        // R10 enable; R9 write of bit0=0 keeps status
        wr_ctrl(8'h02);
        rd(2'd0, v); check("R9 zero write keeps status", {24'd0, v}, 32'h3);
        check("R10 irq enabled", {31'd0, irq}, 32'd1);

        // R7: notify while busy
        run_frame({8'h10, 7'h22, 1'b0, 8'h11, 8'h33}, 4, 1'b0, -1, acks, tok);
        check("R7 nack while busy", {28'd0, acks}, 32'h0);
        check_regs("R7", e_dev, e_lo, e_hi);

        // R9: clear
        wr_ctrl(8'h03);
        rd(2'd0, v); check("R9 cleared", {24'd0, v}, 32'h2);
        check("R10 irq after clear", {31'd0, irq}, 32'd0);

        // R3: read/write bit set
        e_dev = 7'h7F; e_lo = 8'h00; e_hi = 8'hFF;
        run_frame({8'h11, e_dev, 1'b1, e_lo, e_hi}, 4, 1'b0, -1, acks, tok);
        check("R3 acks", {28'd0, acks}, 32'hF);
        check_regs("R3", e_dev, e_lo, e_hi);
        check("R3 irq", {31'd0, irq}, 32'd1);
        wr_ctrl(8'h03);

        // R8: early Stop after three bytes
        run_frame({8'h10, 7'h01, 1'b0, 8'h02, 8'h03}, 3, 1'b0, -1, acks, tok);
        check("R8 early stop acks", {28'd0, acks}, 32'h7);
        rd(2'd0, v); check("R8 early stop status", {24'd0, v}, 32'h2);
        check_regs("R8 early stop", e_dev, e_lo, e_hi);

        // R8: repeated Start after all four bytes
        run_frame({8'h10, 7'h04, 1'b0, 8'h05, 8'h06}, 4, 1'b1, -1, acks, tok);
        check("R8 restart acks", {28'd0, acks}, 32'hF);
        rd(2'd0, v); check("R8 restart status", {24'd0, v}, 32'h2);
        check_regs("R8 restart", e_dev, e_lo, e_hi);

        // R4: full frame to foreign address
        run_frame({8'h12, 7'h09, 1'b0, 8'h0A, 8'h0B}, 4, 1'b0, -1, acks, tok);
        check("R4 foreign acks", {28'd0, acks}, 32'h0);
        rd(2'd0, v); check("R4 foreign status", {24'd0, v}, 32'h2);
        check_regs("R4 foreign", e_dev, e_lo, e_hi);

        // R11: glitch inside first data-low bit
        e_dev = 7'h2A; e_lo = 8'hFF; e_hi = 8'h81;
        run_frame({8'h10, e_dev, 1'b0, e_lo, e_hi}, 4, 1'b0, 2, acks, tok);
        check("R11 glitch acks", {28'd0, acks}, 32'hF);
        check_regs("R11 glitch", e_dev, e_lo, e_hi);
        wr_ctrl(8'h01);

        // R5 / R6: data sweep with computed patterns
        for (int k = 0; k < 6; k++) begin
            e_dev = 7'((k * 23 + 5) % 128);
            e_lo  = 8'((k * 71 + 3) % 256);
            e_hi  = 8'(255 - (k * 45) % 256);
            run_frame({8'h10, e_dev, 1'b0, e_lo, e_hi}, 4, 1'b0, -1, acks, tok);
            check("R5 sweep acks", {28'd0, acks}, 32'hF);
            check_regs("R5 sweep", e_dev, e_lo, e_hi);
            rd(2'd0, v); check("R6 sweep status", {24'd0, v}, 32'h1);
            wr_ctrl(8'h01);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule